// File: doc/BRIEF.md
# Fixed-Priority Restart Vector Encoder

This block merges eight active-low device request lines into one active-high interrupt line to a processor. When the processor acknowledges, the block puts a one-byte restart call opcode on the data bus. That opcode names the highest-numbered device that is requesting service. The opcode has the layout `11nnn111`, where `nnn` is the index of the winning device. Executing it sends the processor to address `nnn * 8` in the lowest 256-byte page.

The block arbitrates by fixed index priority: line 7 wins over every other line and line 0 loses to every other line. Internally the winner is first encoded as an active-low (inverted) index. It is inverted again when the byte is formed, so the true index lands in bits 5..3. The data bus is modelled as a value plus an output-enable flag that stands in for a tri-state driver. While the enable is low the value is forced to zero.

The block samples the acknowledge on the clock. On the first clock edge that sees acknowledge low, it captures the winning index and then holds it for the whole acknowledge. A request that arrives later cannot corrupt a byte the processor is already reading. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `rst_vec_encoder`

## Requirements
- R1: While reset is applied and right after it is released, `irq` is 0, `bus_oe` is 0 and `bus_out` is 8'h00.
- R2: `irq` is 1 one clock edge after any bit of `req_n` is sampled at 0. It is 0 one clock edge after all bits are sampled at 1.
- R3: When several requests are active together, the index encoded is the highest active index. Bit 7 has the highest priority and bit 0 the lowest.
- R4: The driven byte is `{2'b11, idx[2:0], 3'b111}`, with the true index in bits 5..3. For example, index 5 gives 8'hEF.
- R5: `bus_oe` is 1 one clock edge after `ack_n` is sampled at 0, and 0 one clock edge after `ack_n` is sampled at 1. While `bus_oe` is 0, `bus_out` is 8'h00.
- R6: An acknowledge with no request active drives 8'hC7, which is index field 000.
- R7: The index is captured on the first edge that samples `ack_n` low. Request changes during the acknowledge do not change `bus_out` until `ack_n` has been released and asserted again.
- R8: For each index n from 0 to 7, a lone request on line n yields a byte whose bits 5..3 equal n, so its call target is n*8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 8 | Device request lines, active low, bit 7 highest priority |
| ack_n | input | 1 | Interrupt acknowledge from the processor, active low |
| irq | output | 1 | Interrupt request to the processor, active high |
| bus_out | output | 8 | Restart opcode value, 8'h00 when not driven |
| bus_oe | output | 1 | Bus drive enable, models the tri-state driver |

## Verification
Every result is registered once. `irq` follows the request lines after one rising edge, and `bus_oe` and `bus_out` follow `ack_n` after one rising edge. The bench changes inputs on the falling edge and samples outputs on the next falling edge, exactly one rising edge after the stimulus. The hold check asserts a higher-priority request while acknowledge is low, then samples again on later falling edges, so a design that re-encodes on the fly would show a different byte. The release of the enable is checked on the falling edge after the first rising edge that sees `ack_n` high.

// File: rtl/rve_pkg.sv
package rve_pkg;
  localparam int unsigned REQ_N   = 8;
  localparam int unsigned IDX_W   = $clog2(REQ_N);
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FIELD_LO = 3;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Builds the restart byte: all ones except the index field at bits 5..3.
  function automatic byte_t form_restart(input idx_t idx);
    byte_t b;
    b = '1;
    b[FIELD_LO +: IDX_W] = idx;
    return b;
  endfunction
endpackage

// File: rtl/rve_rst_sync.sv
module rve_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rve_prio_enc.sv
module rve_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] active,
  output logic         any,
  output logic [W-1:0] win_idx_n
);
  logic [N-1:0] above;
  logic [N-1:0] grant;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lvl
      if (g == N-1) begin : g_top
        assign above[g] = 1'b0;
      end else begin : g_mid
        assign above[g] = above[g+1] | active[g+1];
      end
      assign grant[g] = active[g] & ~above[g];
    end
  endgenerate

  logic [W-1:0] idx;
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | W'(i);
    end
  end

  assign any       = |active;
  assign win_idx_n = ~idx;
endmodule

// File: rtl/rve_ack_capture.sv
module rve_ack_capture #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         ack_n,
  input  logic [W-1:0] win_idx_n,
  output logic         drive,
  output logic [W-1:0] held_idx_n
);
  logic         drive_d;
  logic         load_en;
  logic [W-1:0] held_d;

  always_comb begin
    drive_d = ~ack_n;
    load_en = ~ack_n & ~drive;
    held_d  = held_idx_n;
    if (load_en) held_d = win_idx_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      drive      <= 1'b0;
      held_idx_n <= '1;
    end else begin
      drive      <= drive_d;
      held_idx_n <= held_d;
    end
  end
endmodule

// File: rtl/rve_opcode_out.sv
module rve_opcode_out
  import rve_pkg::*;
(
  input  logic  drive,
  input  idx_t  held_idx_n,
  output byte_t bus_out,
  output logic  bus_oe
);
  idx_t true_idx;
  assign true_idx = ~held_idx_n;
  assign bus_oe   = drive;
  assign bus_out  = drive ? form_restart(true_idx) : '0;
endmodule

// File: rtl/rst_vec_encoder.sv
module rst_vec_encoder
  import rve_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REQ_N-1:0]  req_n,
  input  logic              ack_n,
  output logic              irq,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe
);
  logic rst_sync_n;
  logic any_req;
  idx_t win_idx_n;
  idx_t held_idx_n;
  logic drive;
  logic irq_d;

  rve_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rve_prio_enc #(.N(REQ_N)) u_enc (
    .active    (~req_n),
    .any       (any_req),
    .win_idx_n (win_idx_n)
  );

  rve_ack_capture #(.W(IDX_W)) u_cap (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .ack_n      (ack_n),
    .win_idx_n  (win_idx_n),
    .drive      (drive),
    .held_idx_n (held_idx_n)
  );

  rve_opcode_out u_out (
    .drive      (drive),
    .held_idx_n (held_idx_n),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe)
  );

  always_comb irq_d = any_req;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq <= 1'b0;
    else             irq <= irq_d;
  end
endmodule

// File: rtl/rve_checker.sv
module rve_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [7:0] req_n,
  input logic       ack_n,
  input logic       irq,
  input logic [7:0] bus_out,
  input logic       bus_oe
);
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_n != 8'hFF) |=> irq); // R2
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_n == 8'hFF) |=> !irq); // R2
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_n[7] && !ack_n && !bus_oe) |=> (bus_out[5:3] == 3'd7)); // R3
  AST_BYTE_FORM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_oe |-> (bus_out[7:6] == 2'b11 && bus_out[2:0] == 3'b111)); // R4
  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ack_n |=> bus_oe); // R5
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_n |=> !bus_oe); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_oe |-> (bus_out == 8'h00)); // R5
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out)); // R7
endmodule

bind rst_vec_encoder rve_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_n      (req_n),
  .ack_n      (ack_n),
  .irq        (irq),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe)
);

// File: tb/sim_rst_vec_encoder.sv
module sim_rst_vec_encoder;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] req_n;
  logic       ack_n;
  logic       irq;
  logic [7:0] bus_out;
  logic       bus_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  rst_vec_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
    .irq(irq), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_byte(input int idx);
    return 8'hC7 | 8'((idx & 7) << 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Assert acknowledge, check the byte, release, check the release.
  task automatic ack_and_check(input string req, input logic [7:0] exp);
    ack_n = 1'b0;
    step();
    check(req, {31'd0, bus_oe}, 32'd1);
    check(req, {24'd0, bus_out}, {24'd0, exp});
    ack_n = 1'b1;
    step();
    check("R5", {31'd0, bus_oe}, 32'd0);
    check("R5", {24'd0, bus_out}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_n = 8'hFF; ack_n = 1'b1;
    repeat (3) step();
    check("R1", {31'd0, irq}, 32'd0);
    check("R1", {31'd0, bus_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1", {31'd0, irq}, 32'd0);
    check("R1", {31'd0, bus_oe}, 32'd0);
    check("R1", {24'd0, bus_out}, 32'd0);
  endtask

  task automatic t_irq;
    req_n = 8'hFB;
    step();
    check("R2", {31'd0, irq}, 32'd1);
    req_n = 8'hFF;
    step();
    check("R2", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_empty_ack;
    req_n = 8'hFF;
    ack_and_check("R6", 8'hC7);
  endtask

  task automatic t_index5;
    req_n = 8'hDF;
    step();
    ack_and_check("R4", 8'hEF);
    req_n = 8'hFF;
    step();
  endtask

  task automatic t_priority;
    req_n = ~8'b0101_0010;
    step();
    ack_and_check("R3", 8'hF7);
    req_n = ~8'b1000_0001;
    step();
    ack_and_check("R3", 8'hFF);
    req_n = 8'hFF;
    step();
  endtask

  task automatic t_all_vectors;
    for (int n = 0; n < 8; n++) begin
      req_n = ~(8'd1 << n);
      step();
      ack_n = 1'b0;
      step();
      check("R8", {29'd0, bus_out[5:3]} * 32'd8, 32'(n * 8));
      check("R8", {24'd0, bus_out}, {24'd0, exp_byte(n)});
      ack_n = 1'b1;
      step();
    end
    req_n = 8'hFF;
    step();
  endtask

  task automatic t_hold;
    req_n = ~8'b0000_0100;
    step();
    ack_n = 1'b0;
    step();
    check("R7", {24'd0, bus_out}, 32'hD7);
    req_n = ~8'b1000_0100;
    step();
    check("R7", {24'd0, bus_out}, 32'hD7);
    step();
    check("R7", {24'd0, bus_out}, 32'hD7);
    ack_n = 1'b1;
    step();
    check("R5", {31'd0, bus_oe}, 32'd0);
    ack_and_check("R7", 8'hFF);
    req_n = 8'hFF;
    step();
  endtask

  initial begin
    t_reset();
    t_irq();
    t_empty_ack();
    t_index5();
    t_priority();
    t_all_vectors();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule